// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block collects up to 32 level-sensitive interrupt requests from peripherals and presents them to a primary interrupt controller in two ways. All sources share one combined request line, which is high whenever any source that software has enabled is active. A fixed group of sources, 21 through 30, can also be routed on their own lines straight to the primary controller. A routed line then follows its source without going through the combined line.

Software reaches the block through a small APB-style register bus. The bus covers a 4 KB window and decodes whole 32-bit words. Through it, software reads the raw and masked source levels, sets and clears bits of the enable mask, uses a shortcut for enable bit 0 (the software-interrupt slot), and sets and clears bits of the routing-enable register. The result lines are bundled on one 32-bit output vector. Each bit keeps the position of the matching primary-controller input: bit 31 is the combined line, bits 21 to 30 are the routed lines, and all other bits stay low.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Each input is sampled on every rising clock edge into a raw level register. A read of word index 1 (byte offset 0x04) returns that register.
- R2: After reset, the raw level, enable mask and routing-enable registers are all zero, and every bit of `irq_out` is low.
- R3: `irq_out[31]` is registered. It is high in the cycle after the raw level ANDed with the enable mask is nonzero, and low in the cycle after it is zero.
- R4: A read of word index 0 (0x00) returns raw level AND enable mask. A read of word index 2 (0x08) returns the enable mask.
- R5: A write to word index 2 ORs the write data into the enable mask. A write to word index 3 (0x0C) clears every mask bit that is 1 in the write data.
- R6: A read of word index 4 (0x10) returns raw level bit 0 in bit 0, with zeros above it. A nonzero write to index 4 sets mask bit 0, and a zero write there changes nothing. A nonzero write to index 5 (0x14) clears mask bit 0.
- R7: A write to word index 8 (0x20) ORs the write data ANDed with 0x7FE00000 into the routing-enable register, so only bits 21 to 30 can become 1. A read of index 8 returns the register.
- R8: A write to word index 9 (0x24) clears every routing-enable bit that is 1 in the write data.
- R9: For each source i from 21 to 30, if its routing-enable bit is set, `irq_out[i]` takes raw level bit i one cycle later. If the bit is clear, `irq_out[i]` keeps its last value.
- R10: Reads of any other word index return 0. Writes to them leave the mask and the routing-enable register unchanged. Bits 0 to 20 of `irq_out` are always low.
- R11: Only `paddr[11:2]` selects the register. `paddr[1:0]` is ignored, and every access is a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high, read when low |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| irq_out | output | 32 | Bit 31 combined line, bits 21 to 30 routed lines, others low |

## Verification
A register write takes effect at the rising edge that ends its access phase, and a read returns the new value in the same cycle that read is issued. `irq_out` changes one edge after that. An input change shows up in the raw level register after one edge, and on `irq_out` after two. The bench drives every stimulus at a falling edge and counts falling edges before it samples. It checks `irq_out` both at the falling edge where the old value must still be present and at the one where the new value is due, so a result that arrives one cycle early or late is caught.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

   // Word indices decoded from paddr[11:2]
   localparam int unsigned IX_MASKED  = 0;
   localparam int unsigned IX_RAW     = 1;
   localparam int unsigned IX_EN_SET  = 2;
   localparam int unsigned IX_EN_CLR  = 3;
   localparam int unsigned IX_SW_SET  = 4;
   localparam int unsigned IX_SW_CLR  = 5;
   localparam int unsigned IX_RT_SET  = 8;
   localparam int unsigned IX_RT_CLR  = 9;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_EN_SET,
      OP_EN_CLR,
      OP_SW_SET,
      OP_SW_CLR,
      OP_RT_SET,
      OP_RT_CLR
   } wr_op_e;

   // Contiguous bit mask from lo to hi inclusive
   function automatic logic [63:0] span_mask(input int lo, input int hi);
      logic [63:0] m;
      m = '0;
      for (int b = 0; b < 64; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/sec_irq_wdec.sv
module sec_irq_wdec
   import sec_irq_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [IDX_W-1:0] idx,
   output wr_op_e           op
);

   always_comb begin
      op = OP_NONE;
      if (psel && penable && pwrite) begin
         case (idx)
            IDX_W'(IX_EN_SET): op = OP_EN_SET;
            IDX_W'(IX_EN_CLR): op = OP_EN_CLR;
            IDX_W'(IX_SW_SET): op = OP_SW_SET;
            IDX_W'(IX_SW_CLR): op = OP_SW_CLR;
            IDX_W'(IX_RT_SET): op = OP_RT_SET;
            IDX_W'(IX_RT_CLR): op = OP_RT_CLR;
            default:           op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
   import sec_irq_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int SW_BIT = 0,
   parameter logic [N_SRC-1:0] RT_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  wr_op_e           op,
   input  logic [N_SRC-1:0] wdata,
   output logic [N_SRC-1:0] raw_q,
   output logic [N_SRC-1:0] mask_q,
   output logic [N_SRC-1:0] rt_q
);

   localparam logic [N_SRC-1:0] SW_ONE = N_SRC'(1) << SW_BIT;

   logic wnz;
   assign wnz = |wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= irq_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else begin
         case (op)
            OP_EN_SET: mask_q <= mask_q | wdata;
            OP_EN_CLR: mask_q <= mask_q & ~wdata;
            OP_SW_SET: if (wnz) mask_q <= mask_q | SW_ONE;
            OP_SW_CLR: if (wnz) mask_q <= mask_q & ~SW_ONE;
            default:   mask_q <= mask_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rt_q <= '0;
      end else begin
         case (op)
            OP_RT_SET: rt_q <= rt_q | (wdata & RT_MASK);
            OP_RT_CLR: rt_q <= rt_q & ~wdata;
            default:   rt_q <= rt_q;
         endcase
      end
   end

endmodule

// File: rtl/sec_irq_rdmux.sv
module sec_irq_rdmux
   import sec_irq_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int IDX_W  = 10,
   parameter int SW_BIT = 0
) (
   input  logic             psel,
   input  logic [IDX_W-1:0] idx,
   input  logic [N_SRC-1:0] raw_q,
   input  logic [N_SRC-1:0] mask_q,
   input  logic [N_SRC-1:0] rt_q,
   output logic [N_SRC-1:0] rdata
);

   logic [N_SRC-1:0] sel_val;

   always_comb begin
      case (idx)
         IDX_W'(IX_MASKED): sel_val = raw_q & mask_q;
         IDX_W'(IX_RAW):    sel_val = raw_q;
         IDX_W'(IX_EN_SET): sel_val = mask_q;
         IDX_W'(IX_SW_SET): sel_val = N_SRC'(raw_q[SW_BIT]);
         IDX_W'(IX_RT_SET): sel_val = rt_q;
         default:           sel_val = '0;
      endcase
   end

   assign rdata = psel ? sel_val : '0;

endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
   parameter int N_SRC    = 32,
   parameter int RT_LO    = 21,
   parameter int RT_HI    = 30,
   parameter int COMB_BIT = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] raw_q,
   input  logic [N_SRC-1:0] mask_q,
   input  logic [N_SRC-1:0] rt_q,
   output logic [N_SRC-1:0] irq_out
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_line
      if (i == COMB_BIT) begin : g_comb
         logic comb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) comb_q <= 1'b0;
            else        comb_q <= |(raw_q & mask_q);
         end
         assign irq_out[i] = comb_q;
      end else if (i >= RT_LO && i <= RT_HI) begin : g_direct
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        line_q <= 1'b0;
            else if (rt_q[i])  line_q <= raw_q[i];
         end
         assign irq_out[i] = line_q;
      end else begin : g_idle
         assign irq_out[i] = 1'b0;
      end
   end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
   import sec_irq_pkg::*;
#(
   parameter int N_SRC    = 32,
   parameter int ADDR_W   = 12,
   parameter int RT_LO    = 21,
   parameter int RT_HI    = 30,
   parameter int COMB_BIT = 31,
   parameter int SW_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [N_SRC-1:0]  pwdata,
   output logic [N_SRC-1:0]  prdata,
   output logic [N_SRC-1:0]  irq_out
);

   localparam int IDX_W = ADDR_W - 2;
   localparam logic [N_SRC-1:0] RT_MASK = N_SRC'(span_mask(RT_LO, RT_HI));

   if (COMB_BIT >= N_SRC || COMB_BIT < 0) begin : g_bad_comb
      $error("COMB_BIT must name a line inside the output vector");
   end
   if (RT_LO > RT_HI || RT_HI >= N_SRC) begin : g_bad_range
      $error("routed range must be ordered and inside the vector");
   end
   if (COMB_BIT >= RT_LO && COMB_BIT <= RT_HI) begin : g_bad_overlap
      $error("combined line may not fall inside the routed range");
   end
   if (ADDR_W < 3 || IDX_W < 4) begin : g_bad_addr
      $error("address window too small for the register set");
   end

   logic [IDX_W-1:0] idx;
   wr_op_e           op;
   logic [N_SRC-1:0] raw_q;
   logic [N_SRC-1:0] mask_q;
   logic [N_SRC-1:0] rt_q;

   assign idx = paddr[ADDR_W-1:2];

   sec_irq_wdec #(.IDX_W(IDX_W)) u_wdec (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .idx     (idx),
      .op      (op)
   );

   sec_irq_regs #(.N_SRC(N_SRC), .SW_BIT(SW_BIT), .RT_MASK(RT_MASK)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .op     (op),
      .wdata  (pwdata),
      .raw_q  (raw_q),
      .mask_q (mask_q),
      .rt_q   (rt_q)
   );

   sec_irq_rdmux #(.N_SRC(N_SRC), .IDX_W(IDX_W), .SW_BIT(SW_BIT)) u_rdmux (
      .psel   (psel),
      .idx    (idx),
      .raw_q  (raw_q),
      .mask_q (mask_q),
      .rt_q   (rt_q),
      .rdata  (prdata)
   );

   sec_irq_route #(
      .N_SRC(N_SRC), .RT_LO(RT_LO), .RT_HI(RT_HI), .COMB_BIT(COMB_BIT)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_q   (raw_q),
      .mask_q  (mask_q),
      .rt_q    (rt_q),
      .irq_out (irq_out)
   );

endmodule

// File: rtl/sec_irq_ctrl_chk.sv
module sec_irq_ctrl_chk #(
   parameter int N_SRC    = 32,
   parameter int ADDR_W   = 12,
   parameter int RT_LO    = 21,
   parameter int RT_HI    = 30,
   parameter int COMB_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  irq_in,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [N_SRC-1:0]  pwdata,
   input logic [N_SRC-1:0]  irq_out,
   input logic [N_SRC-1:0]  raw_q,
   input logic [N_SRC-1:0]  mask_q,
   input logic [N_SRC-1:0]  rt_q
);

   localparam logic [N_SRC-1:0] RT_M =
      N_SRC'(sec_irq_pkg::span_mask(RT_LO, RT_HI));
   localparam logic [N_SRC-1:0] IDLE_M =
      ~(RT_M | (N_SRC'(1) << COMB_BIT));

   logic acc_wr;
   assign acc_wr = psel && penable && pwrite;

   // R1: raw level is the input one edge earlier
   a_r1_raw_sample: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> raw_q == $past(irq_in));

   // R3: combined line rises after active masked sources
   a_r3_comb_high: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw_q & mask_q)) |=> irq_out[COMB_BIT]);

   // R3: combined line falls when nothing masked is active
   a_r3_comb_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw_q & mask_q)) |=> !irq_out[COMB_BIT]);

   // R5: mask clear write leaves none of the named bits set
   a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && paddr[ADDR_W-1:2] == (ADDR_W-2)'(3))
      |=> (mask_q & $past(pwdata)) == '0);

   // R8: routing clear write leaves none of the named bits set
   a_r8_route_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && paddr[ADDR_W-1:2] == (ADDR_W-2)'(9))
      |=> (rt_q & $past(pwdata)) == '0);

   // R9: a routed line without its enable holds its value
   a_r9_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_out ^ $past(irq_out)) & RT_M & ~$past(rt_q)) == '0);

   // R10: lines outside the routed range and combined bit stay low
   a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & IDLE_M) == '0);

endmodule

bind sec_irq_ctrl sec_irq_ctrl_chk #(
   .N_SRC(N_SRC), .ADDR_W(ADDR_W), .RT_LO(RT_LO), .RT_HI(RT_HI),
   .COMB_BIT(COMB_BIT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_in  (irq_in),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .pwdata  (pwdata),
   .irq_out (irq_out),
   .raw_q   (raw_q),
   .mask_q  (mask_q),
   .rt_q    (rt_q)
);

// File: tb/sec_irq_ctrl_bench.sv
module sec_irq_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [31:0] irq_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      string       tag;
      logic [31:0] val;
   } item_t;

   item_t exp_q[$];
   item_t act_q[$];

   always #5 clk = ~clk;

   sec_irq_ctrl u_sec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata),
      .prdata(prdata), .irq_out(irq_out)
   );

   // Monitor: pairs observations with expectations
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t e;
            item_t a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a.val !== e.val) begin
               errors++;
               $display("FAIL %s actual %h expected %h", e.tag, a.val, e.val);
            end
         end
      end
   end

   task automatic expect_val(input string tag, input logic [31:0] v);
      exp_q.push_back('{tag: tag, val: v});
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_read(input string tag, input logic [11:0] a,
                           input logic [31:0] e);
      expect_val(tag, e);
      psel = 1'b1; pwrite = 1'b0; paddr = a;
      #1;
      act_q.push_back('{tag: tag, val: prdata});
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic see_out(input string tag, input logic [31:0] e);
      expect_val(tag, e);
      act_q.push_back('{tag: tag, val: irq_out});
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      while (!finished && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R2: reset state
      see_out("R2 out after reset", 32'h0);
      bus_read("R2 raw reset", 12'h004, 32'h0);
      bus_read("R2 mask reset", 12'h008, 32'h0);
      bus_read("R2 route reset", 12'h020, 32'h0);

      // R1 / R4: raw sampling, masked view empty
      irq_in = 32'h0000_0018;
      tick(1);
      bus_read("R1 raw follows input", 12'h004, 32'h0000_0018);
      bus_read("R4 masked empty", 12'h000, 32'h0);
      see_out("R3 comb low unmasked", 32'h0);

      // R5 / R3: enable set and cycle timing of combined line
      bus_write(12'h008, 32'h0000_0010);
      see_out("R3 comb not yet high", 32'h0);
      tick(1);
      see_out("R3 comb high", 32'h8000_0000);
      bus_read("R4 masked view", 12'h000, 32'h0000_0010);
      bus_write(12'h008, 32'h0000_0008);
      bus_read("R5 set ORs", 12'h008, 32'h0000_0018);
      bus_write(12'h00C, 32'h0000_0010);
      bus_read("R5 clear one bit", 12'h008, 32'h0000_0008);
      see_out("R3 comb stays high", 32'h8000_0000);
      bus_write(12'h00C, 32'h0000_0008);
      see_out("R3 comb still high one cycle", 32'h8000_0000);
      tick(1);
      see_out("R3 comb low after clear", 32'h0);

      // R6: software-interrupt slot
      bus_read("R6 bit0 view zero", 12'h010, 32'h0);
      irq_in = 32'h0000_0019;
      tick(1);
      bus_read("R6 bit0 view one", 12'h010, 32'h0000_0001);
      bus_write(12'h010, 32'h0);
      bus_read("R6 zero write ignored", 12'h008, 32'h0);
      bus_write(12'h010, 32'h0000_0080);
      bus_read("R6 nonzero sets bit0", 12'h008, 32'h0000_0001);
      see_out("R6 comb from bit0", 32'h8000_0000);
      bus_write(12'h014, 32'h0000_0004);
      bus_read("R6 nonzero clears bit0", 12'h008, 32'h0);
      tick(1);
      see_out("R6 comb low again", 32'h0);

      // R7 / R9: routing enable and routed lines
      bus_write(12'h020, 32'hFFFF_FFFF);
      bus_read("R7 only range bits", 12'h020, 32'h7FE0_0000);
      irq_in = 32'h4020_0000;
      tick(1);
      see_out("R9 routed not yet", 32'h0);
      tick(1);
      see_out("R9 routed follow", 32'h4020_0000);

      // R8 / R9: clear one route, that line holds
      bus_write(12'h024, 32'h4000_0000);
      bus_read("R8 route clear", 12'h020, 32'h3FE0_0000);
      irq_in = 32'h0;
      tick(2);
      see_out("R9 disabled line holds", 32'h4000_0000);

      // R10: unlisted indices
      bus_write(12'h018, 32'hFFFF_FFFF);
      bus_write(12'h01C, 32'hFFFF_FFFF);
      bus_write(12'h028, 32'hFFFF_FFFF);
      bus_write(12'hFFC, 32'hFFFF_FFFF);
      bus_read("R10 read idx6", 12'h018, 32'h0);
      bus_read("R10 read idx10", 12'h028, 32'h0);
      bus_read("R10 read top", 12'hFFC, 32'h0);
      bus_read("R10 mask untouched", 12'h008, 32'h0);
      bus_read("R10 route untouched", 12'h020, 32'h3FE0_0000);
      irq_in = 32'hFFFF_FFFF;
      tick(2);
      see_out("R10 low bits stay low", 32'h7FE0_0000);

      // R11: low address bits ignored
      bus_write(12'h009, 32'h0000_0002);
      tick(1);
      see_out("R11 unaligned enable", 32'hFFE0_0000);
      bus_read("R11 unaligned read mask", 12'h00B, 32'h0000_0002);
      bus_read("R11 unaligned read masked", 12'h003, 32'h0000_0002);

      tick(3);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule